// File: doc/BRIEF.md
# Feedback Stochastic Divider

This block divides two unsigned fractions, a dividend `x` and a divisor `k`, both given as W-bit binary numbers read as value/2^W. The division happens in the stochastic domain. Each operand drives its own comparator-based stream generator. Each generator has a maximal-length LFSR with its own seed, and the divisor generator compares against the bit-reversed LFSR state. The dividend stream enters a non-scaled adder. The adder's second input is a feedback term: the previous output bit ANDed with the inverted divisor bit. At equilibrium the output density d satisfies d = x + d·(1−k), so d = x/k. The two operand streams need no correlation with each other, so neither stream has to be regenerated. A ones-counter runs over N = 2^W stream cycles and gives the binary quotient scaled by N.

Operands arrive on a valid/ready request channel. Results leave on a valid/ready result channel. Back-pressure works as follows. A request is taken only on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is low for the whole time a division is streaming. A finished result stays on the result channel, unchanged, until the consumer raises `out_ready`. In the cycle the result is taken, a new request can be accepted at the same edge. If the divisor is out of its legal range, the block skips streaming. It flags the result and saturates the quotient.

Top module: `sdiv_feedback`

## Requirements
- R1: `in_ready` is 1 when the block is idle, and also when a result is held while `out_ready` is 1. It is 0 while a division streams. After reset `in_ready`=1 and `out_valid`=0.
- R2: Both stream generators reload their seeds at every accepted request. Identical operands therefore always give an identical quotient. The LFSR states are never zero. A stream bit is 1 when the operand is greater than or equal to the random value.
- R3: In the non-scaled adder, a dividend bit of 1 always gives an output bit of 1. Extra ones are placed only in cycles where the dividend bit is 0: from the feedback bit, or from a stored credit of feedback ones that collided with dividend ones.
- R4: The feedback bit is the previous output bit AND NOT the divisor bit. For a legal pair, the quotient is within 64 of round(2^W·x/k), capped at 2^W−1. Over a sweep of legal pairs, the mean absolute error divided by 2^W is below 0.05.
- R5: A dividend of 0 with a legal divisor gives a quotient of exactly 0.
- R6: A divisor of 0, or a divisor below the dividend, sets `out_range_err`=1 and gives `out_quotient` of all ones. Otherwise `out_range_err`=0.
- R7: A legal request presents `out_valid` after the 2^W-th rising edge that follows the accepting edge. An illegal request presents it right after the accepting edge.
- R8: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_quotient` and `out_range_err` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be taken this cycle |
| in_dividend | input | W | Dividend x, value/2^W |
| in_divisor | input | W | Divisor k, value/2^W |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_quotient | output | W | Ones count over 2^W cycles (≈ 2^W·x/k) |
| out_range_err | output | 1 | Divisor was zero or below the dividend |

## Verification
Two things can happen at the same clock edge: handing off a finished quotient, and accepting the next request. With `out_ready` held high, requests are driven back to back. Each new pair is then accepted at the edge where the previous result leaves. The bench checks that `in_ready` is high whenever a result is being taken. It also checks that the latency of the new pair still counts from that shared edge, and that its quotient is as correct as an isolated one. A second phase throttles `out_ready` and checks that the held result does not move.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } sdiv_state_t;

  // Right-shift Galois masks for maximal-length sequences.
  function automatic logic [31:0] lfsr_mask(input int w);
    case (w)
      4:       return 32'h0000_000C;
      5:       return 32'h0000_0014;
      6:       return 32'h0000_0030;
      7:       return 32'h0000_0060;
      9:       return 32'h0000_0110;
      10:      return 32'h0000_0240;
      11:      return 32'h0000_0500;
      12:      return 32'h0000_0E08;
      13:      return 32'h0000_1C80;
      14:      return 32'h0000_3802;
      15:      return 32'h0000_6000;
      16:      return 32'h0000_B400;
      default: return 32'h0000_00B8;
    endcase
  endfunction

endpackage

// File: rtl/sdiv_lfsr.sv
module sdiv_lfsr #(
  parameter int W = 8,
  parameter logic [W-1:0] SEED = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  output logic [W-1:0] rnd
);
  localparam logic [31:0] MASK_FULL = sdiv_pkg::lfsr_mask(W);
  localparam logic [W-1:0] MASK = MASK_FULL[W-1:0];

  logic [W-1:0] st;

  always_ff @(posedge clk) begin
    if (!rst_n)     st <= SEED;
    else if (load)  st <= SEED;
    else if (step)  st <= (st >> 1) ^ (st[0] ? MASK : '0);
  end

  assign rnd = st;

  p_state_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st != '0);
endmodule

// File: rtl/sdiv_sng.sv
module sdiv_sng #(
  parameter int W = 8,
  parameter logic [W-1:0] SEED = 1,
  parameter bit REVERSE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] value,
  output logic         bit_o
);
  logic [W-1:0] rnd;
  logic [W-1:0] rnd_used;

  sdiv_lfsr #(.W(W), .SEED(SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step), .rnd(rnd)
  );

  generate
    if (REVERSE) begin : g_rev
      for (genvar i = 0; i < W; i++) begin : g_bit
        assign rnd_used[i] = rnd[W-1-i];
      end
    end else begin : g_fwd
      assign rnd_used = rnd;
    end
  endgenerate

  assign bit_o = (value >= rnd_used);
endmodule

// File: rtl/sdiv_nsadd.sv
module sdiv_nsadd #(
  parameter int CW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic a_i,
  input  logic b_i,
  output logic y_o
);
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] credit;
  logic          has_credit;

  assign has_credit = (credit != '0);
  assign y_o = a_i | b_i | has_credit;

  always_ff @(posedge clk) begin
    if (!rst_n)       credit <= '0;
    else if (clr)     credit <= '0;
    else if (en) begin
      if (a_i && b_i && credit != CMAX)   credit <= credit + 1'b1;
      else if (!a_i && !b_i && has_credit) credit <= credit - 1'b1;
    end
  end

  p_dividend_ones_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && a_i) |-> y_o);
endmodule

// File: rtl/sdiv_feedback.sv
module sdiv_feedback #(
  parameter int W = 8,
  parameter int CW = 4,
  parameter int SEED_X = 'h5A,
  parameter int SEED_K = 'hC3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_dividend,
  input  logic [W-1:0] in_divisor,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_quotient,
  output logic         out_range_err
);
  import sdiv_pkg::*;

  localparam logic [W-1:0] QMAX = '1;
  localparam logic [W-1:0] SX = W'(SEED_X);
  localparam logic [W-1:0] SK = W'(SEED_K);

  sdiv_state_t  state;
  logic [W-1:0] x_q, k_q, cyc_cnt, quot_q;
  logic [W:0]   ones_cnt, ones_next;
  logic         err_q, out_q;
  logic         accept, bad_req, step;
  logic         x_bit, k_bit, fb_bit, sum_bit;

  assign in_ready  = (state == ST_IDLE) || ((state == ST_DONE) && out_ready);
  assign accept    = in_valid && in_ready;
  assign bad_req   = (in_divisor == '0) || (in_divisor < in_dividend);
  assign step      = (state == ST_RUN);
  assign out_valid = (state == ST_DONE);
  assign out_quotient  = quot_q;
  assign out_range_err = err_q;

  sdiv_sng #(.W(W), .SEED(SX), .REVERSE(1'b0)) u_sng_x (
    .clk(clk), .rst_n(rst_n), .load(accept), .step(step),
    .value(x_q), .bit_o(x_bit)
  );

  sdiv_sng #(.W(W), .SEED(SK), .REVERSE(1'b1)) u_sng_k (
    .clk(clk), .rst_n(rst_n), .load(accept), .step(step),
    .value(k_q), .bit_o(k_bit)
  );

  // Feedback: previous output kept only where the divisor bit is 0.
  assign fb_bit = out_q & ~k_bit;

  sdiv_nsadd #(.CW(CW)) u_nsadd (
    .clk(clk), .rst_n(rst_n), .clr(accept), .en(step),
    .a_i(x_bit), .b_i(fb_bit), .y_o(sum_bit)
  );

  assign ones_next = ones_cnt + {{W{1'b0}}, sum_bit};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      x_q      <= '0;
      k_q      <= '0;
      cyc_cnt  <= '0;
      ones_cnt <= '0;
      out_q    <= 1'b0;
      quot_q   <= '0;
      err_q    <= 1'b0;
    end else begin
      case (state)
        ST_RUN: begin
          out_q    <= sum_bit;
          ones_cnt <= ones_next;
          cyc_cnt  <= cyc_cnt + 1'b1;
          if (cyc_cnt == QMAX) begin
            quot_q <= (ones_next > {1'b0, QMAX}) ? QMAX : ones_next[W-1:0];
            state  <= ST_DONE;
          end
        end
        default: begin
          if (accept) begin
            x_q      <= in_dividend;
            k_q      <= in_divisor;
            cyc_cnt  <= '0;
            ones_cnt <= '0;
            out_q    <= 1'b0;
            if (bad_req) begin
              err_q  <= 1'b1;
              quot_q <= QMAX;
              state  <= ST_DONE;
            end else begin
              err_q  <= 1'b0;
              state  <= ST_RUN;
            end
          end else if (state == ST_DONE && out_ready) begin
            state <= ST_IDLE;
          end
        end
      endcase
    end
  end

  p_busy_blocks_input_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |-> !in_ready);

  p_zero_dividend_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && x_q == '0) |-> !sum_bit);

  p_err_saturates_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_range_err) |-> (out_quotient == QMAX));

  p_result_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_quotient) && $stable(out_range_err)));
endmodule

// File: tb/sdiv_feedback_tb_top.sv
module sdiv_feedback_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int N = 1 << W;
  localparam int WD_LIMIT = 150000;

  typedef struct {
    int x;
    int k;
    int acc;
    bit rep;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [W-1:0] in_dividend = '0;
  logic [W-1:0] in_divisor = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [W-1:0] out_quotient;
  logic out_range_err;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int legal_n = 0;
  int abs_sum = 0;
  int last_q = -1;
  bit bp_mode = 1'b0;
  bit done = 1'b0;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdiv_feedback #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_dividend(in_dividend), .in_divisor(in_divisor),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_quotient(out_quotient), .out_range_err(out_range_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // Driver: called at a negedge; pushes the expected item at acceptance.
  task automatic send(input int x, input int k, input bit rep);
    bit ok;
    item_t it;
    in_valid    = 1'b1;
    in_dividend = W'(x);
    in_divisor  = W'(k);
    ok = 1'b0;
    while (!ok) begin
      #(CLK_PERIOD/4);
      if (out_valid && out_ready)
        check(in_ready == 1'b1, "R1 accept during handoff", int'(in_ready), 1);
      ok = in_ready;
      if (!ok) @(negedge clk);
    end
    it.x = x; it.k = k; it.acc = cyc + 1; it.rep = rep;
    sb.push_back(it);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic score(input item_t it, input int qv, input bit ev);
    bit bad;
    int exp, diff;
    bad = (it.k == 0) || (it.k < it.x);
    check(ev == bad, "R6 error flag", int'(ev), int'(bad));
    if (bad) begin
      check(qv == N - 1, "R6 saturated quotient", qv, N - 1);
    end else if (it.x == 0) begin
      check(qv == 0, "R5 zero dividend", qv, 0);
    end else begin
      exp = (2 * N * it.x + it.k) / (2 * it.k);
      if (exp > N - 1) exp = N - 1;
      diff = (qv > exp) ? qv - exp : exp - qv;
      abs_sum += diff;
      legal_n++;
      check(diff <= 64, "R4 quotient accuracy", qv, exp);
    end
    if (it.rep) check(qv == last_q, "R2 repeatable result", qv, last_q);
    last_q = qv;
  endtask

  // Monitor / scoreboard: pops expected items as results are taken.
  initial begin : monitor
    bit seen, stall, r;
    int hold_q;
    bit hold_e;
    item_t head;
    seen = 1'b0; stall = 1'b0; hold_q = 0; hold_e = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (stall) begin
          check(out_valid == 1'b1, "R8 valid held", int'(out_valid), 1);
          check(int'(out_quotient) == hold_q, "R8 quotient held", int'(out_quotient), hold_q);
          check(out_range_err == hold_e, "R8 flag held", int'(out_range_err), int'(hold_e));
        end
        if (out_valid && !seen) begin
          seen = 1'b1;
          if (sb.size() == 0) begin
            check(1'b0, "R7 unexpected result", 1, 0);
          end else begin
            head = sb[0];
            if ((head.k == 0) || (head.k < head.x))
              check(cyc == head.acc, "R7 error latency", cyc - head.acc, 0);
            else
              check(cyc == head.acc + N, "R7 stream latency", cyc - head.acc, N);
          end
        end
        r = bp_mode ? ((cyc % 3) == 0) : 1'b1;
        out_ready = r;
        if (out_valid) begin
          if (r) begin
            if (sb.size() != 0) begin
              head = sb.pop_front();
              score(head, int'(out_quotient), out_range_err);
            end
            seen = 1'b0;
            stall = 1'b0;
          end else begin
            stall = 1'b1;
            hold_q = int'(out_quotient);
            hold_e = out_range_err;
          end
        end else begin
          stall = 1'b0;
        end
      end
    end
  end

  initial begin : watchdog
    forever begin
      @(posedge clk);
      if (cyc > WD_LIMIT && !done) begin
        check(1'b0, "watchdog expired", cyc, WD_LIMIT);
        summary();
      end
    end
  end

  initial begin : stimulus
    int klist[5];
    real mae;
    klist = '{64, 100, 128, 200, 255};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1 reset in_ready", int'(in_ready), 1);
    check(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);

    // Phase A: consumer always ready, requests back to back.
    foreach (klist[i]) begin
      for (int j = 0; j <= 4; j++) send((klist[i] * j) / 4, klist[i], 1'b0);
    end
    send(0, 0, 1'b0);
    send(20, 10, 1'b0);
    send(5, 0, 1'b0);
    send(100, 160, 1'b0);
    send(100, 160, 1'b1);

    // Phase B: throttled consumer.
    bp_mode = 1'b1;
    send(45, 180, 1'b0);
    send(50, 30, 1'b0);
    send(90, 180, 1'b0);
    send(135, 180, 1'b0);
    send(0, 77, 1'b0);

    while (sb.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    mae = (legal_n > 0) ? (real'(abs_sum) / real'(legal_n)) / real'(N) : 1.0;
    check(mae < 0.05, "R4 mean error x1000", int'(mae * 1000.0), 50);
    done = 1'b1;
    summary();
  end
endmodule